// File: doc/BRIEF.md
# Rearmable Countdown Watchdog Timer

This block is a supervision timer for a larger system. A down-counter runs from the block clock and loses one step on every cycle while the timer is armed. Software keeps the system alive by rewriting a preset value before the count runs out. The preset sets the timeout length in clock cycles. When the count has reached zero, the timer fires and raises its fire output.

A fired timer latches. It stays fired, with the counter parked at zero, until software writes the rearm bit in the control word. Writing a new preset to a fired timer only updates the stored preset, so the system cannot recover just by reloading the counter. On rearm the counter reloads from the stored preset.

A second output, the granted indication, is high only while the timer is armed and has not fired. A configuration bit returns the whole block to its reset state. The register interface is a single-cycle write port and a combinational read port.

Top module: `rearm_watchdog`

## Requirements
- R1: After reset (`rst_n` low), `wd_fire_o` and `granted_o` are low, and the control word (address 0), the preset (address 1) and the counter (address 3) all read 0.
- R2: A write to address 1 stores its data in the preset register. When the timer is not fired, the same write also loads the data into the counter.
- R3: While the timer is armed and not fired, with no write, a nonzero counter falls by exactly 1 on every clock edge.
- R4: While the timer is armed and not fired, with no write, a counter at zero sets the fired state on the next edge. After that edge `wd_fire_o` is high, `granted_o` is low and the counter stays at 0.
- R5: While the timer is fired, only a rearm or a soft reset clears it. A preset write updates the preset register (address 1), but the fire output stays high and the counter stays at 0.
- R6: A write to address 0 with bit 1 set rearms the timer: it clears the fired state, sets the armed state and reloads the counter from the preset register. A write to address 0 with bit 1 clear has no effect.
- R7: Reading address 0 returns the fired state in bit 0 and the armed state in bit 1. All other bits read 0. Address 2 reads 0.
- R8: A preset of 0 written to an armed, running timer fires it one edge after the write lands.
- R9: A write to address 2 with bit 0 set returns every register to its R1 state on the next edge. With bit 0 clear, the write has no effect.
- R10: `granted_o` is high exactly while the timer is armed and not fired. While the timer is disarmed, the counter holds its value and the timer never fires.
- R11: A preset write that lands on the same edge where a running counter would fire (counter at 0) reloads the counter, and the timer does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the countdown runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (2) | Write address: 0 control, 1 preset, 2 config |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (2) | Read address: 0 control, 1 preset, 2 config, 3 counter |
| rd_data | output | DATA_W (32) | Combinational read data |
| wd_fire_o | output | 1 | High while the timer is fired |
| granted_o | output | 1 | High while the timer is armed and has not fired |

## Verification
The bound checker watches the following on every cycle:
- the single-step countdown;
- the firing edge when the count is zero;
- the latching of the fired state against preset writes;
- the reload on rearm;
- the clearing effect of a soft reset;
- the frozen counter while disarmed;
- the mutual exclusion of the fire and granted outputs.

Some behaviour can only be shown by the bench's scenarios, since each depends on a particular order of register writes:
- the preset register update hidden behind a fired timer;
- the no-effect writes with the control bits clear;
- the reload that wins against firing on the same edge;
- the preset of zero;
- a long run of periodic reloads that must keep the timer granted.

// File: rtl/rearm_watchdog_pkg.sv
package rearm_watchdog_pkg;

   // Register selector codes (low two bits of the address).
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_PRESET = 2'd1,
      SEL_CFG    = 2'd2,
      SEL_COUNT  = 2'd3
   } reg_sel_e;

   // Bit positions inside the control and config words.
   localparam int unsigned CTRL_FIRED_BIT = 0;
   localparam int unsigned CTRL_ARMED_BIT = 1;
   localparam int unsigned CTRL_REARM_BIT = 1;
   localparam int unsigned CFG_SRST_BIT   = 0;

   // Minimum address width that still reaches every register.
   localparam int unsigned MIN_ADDR_W = 2;

   // Address match helper: full-width compare against a selector code.
   function automatic logic addr_is(input logic [31:0] addr, input int unsigned addr_w,
                                    input reg_sel_e sel);
      logic [31:0] mask;
      mask = (addr_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << addr_w) - 32'd1);
      return ((addr & mask) == {30'd0, sel});
   endfunction

endpackage

// File: rtl/rearm_watchdog_regif.sv
module rearm_watchdog_regif
   import rearm_watchdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              fired,
   input  logic              armed,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  preset,
   output logic              rearm_req,
   output logic              load_req,
   output logic              srst_req,
   output logic [CNT_W-1:0]  load_val,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned EXT_W = DATA_W - CNT_W;

   logic [31:0] wr_addr32;
   logic [31:0] rd_addr32;
   logic        hit_ctrl;
   logic        hit_preset;
   logic        hit_cfg;
   logic [DATA_W-1:0] count_ext;
   logic [DATA_W-1:0] preset_ext;
   logic [DATA_W-1:0] ctrl_word;

   assign wr_addr32 = 32'(wr_addr);
   assign rd_addr32 = 32'(rd_addr);

   assign hit_ctrl   = addr_is(wr_addr32, ADDR_W, SEL_CTRL);
   assign hit_preset = addr_is(wr_addr32, ADDR_W, SEL_PRESET);
   assign hit_cfg    = addr_is(wr_addr32, ADDR_W, SEL_CFG);

   assign rearm_req = wr_en & hit_ctrl   & wr_data[CTRL_REARM_BIT];
   assign load_req  = wr_en & hit_preset;
   assign srst_req  = wr_en & hit_cfg    & wr_data[CFG_SRST_BIT];
   assign load_val  = wr_data[CNT_W-1:0];

   // Width adaptation between counter and data bus.
   generate
      if (EXT_W == 0) begin : g_same_w
         assign count_ext  = count;
         assign preset_ext = preset;
      end else begin : g_zero_ext
         assign count_ext  = {{EXT_W{1'b0}}, count};
         assign preset_ext = {{EXT_W{1'b0}}, preset};
      end
   endgenerate

   always_comb begin
      ctrl_word                 = '0;
      ctrl_word[CTRL_FIRED_BIT] = fired;
      ctrl_word[CTRL_ARMED_BIT] = armed;
   end

   always_comb begin
      if (addr_is(rd_addr32, ADDR_W, SEL_CTRL))
         rd_data = ctrl_word;
      else if (addr_is(rd_addr32, ADDR_W, SEL_PRESET))
         rd_data = preset_ext;
      else if (addr_is(rd_addr32, ADDR_W, SEL_COUNT))
         rd_data = count_ext;
      else
         rd_data = '0;
   end

endmodule

// File: rtl/rearm_watchdog_counter.sv
module rearm_watchdog_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst_req,
   input  logic             rearm_req,
   input  logic             load_req,
   input  logic [CNT_W-1:0] load_val,
   input  logic             running,
   input  logic             fired,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] preset_q,
   output logic             at_zero
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_d;
   logic [CNT_W-1:0] preset_d;

   assign at_zero = (count_q == '0);

   // Preset store: updated by every preset write, fired or not.
   always_comb begin
      preset_d = preset_q;
      if (srst_req)
         preset_d = '0;
      else if (load_req)
         preset_d = load_val;
   end

   // Count: soft reset > rearm reload > preset load > countdown.
   always_comb begin
      count_d = count_q;
      if (srst_req)
         count_d = '0;
      else if (rearm_req)
         count_d = preset_q;
      else if (load_req && !fired)
         count_d = load_val;
      else if (running && !at_zero)
         count_d = count_q - CNT_ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         preset_q <= '0;
      end else begin
         count_q  <= count_d;
         preset_q <= preset_d;
      end
   end

endmodule

// File: rtl/rearm_watchdog_ctl.sv
module rearm_watchdog_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic srst_req,
   input  logic rearm_req,
   input  logic load_req,
   input  logic at_zero,
   output logic armed_q,
   output logic fired_q,
   output logic running
);

   logic armed_d;
   logic fired_d;
   logic expire;

   assign running = armed_q & ~fired_q;
   // A preset write on the expiry edge wins and keeps the timer alive.
   assign expire  = running & at_zero & ~load_req;

   always_comb begin
      armed_d = armed_q;
      fired_d = fired_q;
      if (srst_req) begin
         armed_d = 1'b0;
         fired_d = 1'b0;
      end else if (rearm_req) begin
         armed_d = 1'b1;
         fired_d = 1'b0;
      end else if (expire) begin
         fired_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         fired_q <= 1'b0;
      end else begin
         armed_q <= armed_d;
         fired_q <= fired_d;
      end
   end

endmodule

// File: rtl/rearm_watchdog.sv
module rearm_watchdog
   import rearm_watchdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              wd_fire_o,
   output logic              granted_o
);

   // Elaboration-time parameter checks.
   generate
      if (ADDR_W < MIN_ADDR_W || ADDR_W > 32) begin : g_bad_addr_w
         $error("rearm_watchdog: ADDR_W out of range");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("rearm_watchdog: CNT_W must be within 1..DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("rearm_watchdog: DATA_W too narrow for control bits");
      end
   endgenerate

   logic             rearm_req;
   logic             load_req;
   logic             srst_req;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] preset_q;
   logic             at_zero;
   logic             armed_q;
   logic             fired_q;
   logic             running;

   rearm_watchdog_regif #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_regif (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .fired     (fired_q),
      .armed     (armed_q),
      .count     (count_q),
      .preset    (preset_q),
      .rearm_req (rearm_req),
      .load_req  (load_req),
      .srst_req  (srst_req),
      .load_val  (load_val),
      .rd_data   (rd_data)
   );

   rearm_watchdog_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst_req  (srst_req),
      .rearm_req (rearm_req),
      .load_req  (load_req),
      .load_val  (load_val),
      .running   (running),
      .fired     (fired_q),
      .count_q   (count_q),
      .preset_q  (preset_q),
      .at_zero   (at_zero)
   );

   rearm_watchdog_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst_req  (srst_req),
      .rearm_req (rearm_req),
      .load_req  (load_req),
      .at_zero   (at_zero),
      .armed_q   (armed_q),
      .fired_q   (fired_q),
      .running   (running)
   );

   assign wd_fire_o = fired_q;
   assign granted_o = running;

endmodule

// File: rtl/rearm_watchdog_chk.sv
module rearm_watchdog_chk #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              wr_bit0,
   input logic              wr_bit1,
   input logic [CNT_W-1:0]  count,
   input logic [CNT_W-1:0]  preset,
   input logic              armed,
   input logic              fired,
   input logic              wd_fire_o,
   input logic              granted_o
);

   logic rearm_w;
   logic srst_w;
   logic run;

   assign rearm_w = wr_en && (wr_addr == ADDR_W'(0)) && wr_bit1;
   assign srst_w  = wr_en && (wr_addr == ADDR_W'(2)) && wr_bit0;
   assign run     = armed && !fired;

   // R3: one step down per cycle while running
   assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run && (count != '0) && !wr_en |=> count == $past(count) - CNT_W'(1));

   // R4: zero count while running fires on the next edge
   assert_fire_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run && (count == '0) && !wr_en |=> wd_fire_o && !granted_o);

   // R5: fired state latches, counter parked at zero
   assert_fire_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fired && !rearm_w && !srst_w |=> wd_fire_o && (count == '0));

   // R6: rearm reloads from preset and grants
   assert_rearm_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rearm_w |=> granted_o && !wd_fire_o && (count == $past(preset)));

   // R9: soft reset clears everything
   assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst_w |=> !wd_fire_o && !granted_o && (count == '0) && (preset == '0));

   // R10: fire and granted never both high
   assert_out_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wd_fire_o, granted_o}));

   // R10: disarmed counter holds and never fires
   assert_disarmed_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !armed && !fired && !wr_en |=> $stable(count) && !wd_fire_o);

endmodule

bind rearm_watchdog rearm_watchdog_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_bit0   (wr_data[0]),
   .wr_bit1   (wr_data[1]),
   .count     (count_q),
   .preset    (preset_q),
   .armed     (armed_q),
   .fired     (fired_q),
   .wd_fire_o (wd_fire_o),
   .granted_o (granted_o)
);

// File: tb/rearm_watchdog_tb.sv
`timescale 1ns/1ps
module rearm_watchdog_tb;

   localparam int ADDR_W = 2;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [DATA_W-1:0] rd_data;
   logic              wd_fire_o;
   logic              granted_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_tag = "R1";
   logic [1:0] rot = '0;

   // Behavioural reference state
   logic [31:0] m_count = '0;
   logic [31:0] m_preset = '0;
   bit m_armed = 0;
   bit m_fired = 0;

   always #2.5 clk = ~clk;

   rearm_watchdog u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .wd_fire_o (wd_fire_o),
      .granted_o (granted_o)
   );

   function automatic logic [31:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: m_read = {30'd0, m_armed, m_fired};
         2'd1: m_read = m_preset;
         2'd3: m_read = m_count;
         default: m_read = '0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_count = '0; m_preset = '0; m_armed = 0; m_fired = 0;
      end else begin
         bit run;
         run = m_armed && !m_fired;
         if (wr_en && wr_addr == 2'd2 && wr_data[0]) begin
            m_count = '0; m_preset = '0; m_armed = 0; m_fired = 0;
         end else if (wr_en && wr_addr == 2'd0 && wr_data[1]) begin
            m_armed = 1; m_fired = 0; m_count = m_preset;
         end else if (wr_en && wr_addr == 2'd1) begin
            m_preset = wr_data;
            if (!m_fired) m_count = wr_data;
         end else if (run) begin
            if (m_count == 0) m_fired = 1;
            else m_count = m_count - 1;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison against the reference
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         check({cur_tag, " fire"}, 32'(wd_fire_o), 32'(m_fired));
         check({cur_tag, " granted"}, 32'(granted_o), 32'(m_armed && !m_fired));
         check({cur_tag, " read"}, rd_data, m_read(rd_addr));
      end
   end

   task automatic step(input bit we, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      rd_addr = rot; rot = rot + 2'd1;
      @(posedge clk);
      #2;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0);
   endtask

   task automatic peek(input string tag, input logic [1:0] a, input logic [31:0] exp);
      rd_addr = a;
      #0.2;
      check(tag, rd_data, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #2;
      // R1: reset state
      cur_tag = "R1";
      check("R1 fire", 32'(wd_fire_o), 32'd0);
      check("R1 granted", 32'(granted_o), 32'd0);
      peek("R1 ctrl", 2'd0, 32'd0);
      peek("R1 preset", 2'd1, 32'd0);
      peek("R1 count", 2'd3, 32'd0);

      // R2: preset load while disarmed; R10: disarmed counter holds
      cur_tag = "R2";
      step(1'b1, 2'd1, 32'd10);
      peek("R2 count", 2'd3, 32'd10);
      peek("R2 preset", 2'd1, 32'd10);
      cur_tag = "R10";
      idle(3);
      peek("R10 disarmed hold", 2'd3, 32'd10);
      check("R10 granted low disarmed", 32'(granted_o), 32'd0);

      // R6: rearm grants and reloads; R3: countdown
      cur_tag = "R6";
      step(1'b1, 2'd0, 32'h2);
      check("R6 granted", 32'(granted_o), 32'd1);
      peek("R6 reload", 2'd3, 32'd10);
      cur_tag = "R3";
      step(1'b0, 2'd0, 32'd0);
      peek("R3 dec", 2'd3, 32'd9);
      idle(9);
      peek("R3 reached zero", 2'd3, 32'd0);
      check("R3 not yet fired", 32'(wd_fire_o), 32'd0);

      // R4: fire on next edge; R7: control readback
      cur_tag = "R4";
      step(1'b0, 2'd0, 32'd0);
      check("R4 fire", 32'(wd_fire_o), 32'd1);
      check("R4 granted", 32'(granted_o), 32'd0);
      peek("R7 ctrl word", 2'd0, 32'd3);
      peek("R7 cfg reads zero", 2'd2, 32'd0);

      // R5: preset write does not clear fired
      cur_tag = "R5";
      step(1'b1, 2'd1, 32'd50);
      check("R5 still fired", 32'(wd_fire_o), 32'd1);
      peek("R5 count parked", 2'd3, 32'd0);
      peek("R5 preset updated", 2'd1, 32'd50);
      idle(3);
      check("R5 stays fired", 32'(wd_fire_o), 32'd1);

      // R6: control write without rearm bit is ignored
      cur_tag = "R6";
      step(1'b1, 2'd0, 32'h1);
      check("R6 no-rearm ignored", 32'(wd_fire_o), 32'd1);
      peek("R6 no-rearm count", 2'd3, 32'd0);
      step(1'b1, 2'd0, 32'h2);
      check("R6 cleared", 32'(wd_fire_o), 32'd0);
      peek("R6 reload 50", 2'd3, 32'd50);

      // R11: reload on the expiry edge wins
      cur_tag = "R11";
      step(1'b1, 2'd1, 32'd3);
      idle(3);
      peek("R11 at zero", 2'd3, 32'd0);
      step(1'b1, 2'd1, 32'd3);
      check("R11 no fire", 32'(wd_fire_o), 32'd0);
      peek("R11 reloaded", 2'd3, 32'd3);
      idle(4);
      check("R4 fires after kick", 32'(wd_fire_o), 32'd1);

      // R8: preset of zero while running
      cur_tag = "R8";
      step(1'b1, 2'd0, 32'h2);
      step(1'b1, 2'd1, 32'd0);
      check("R8 not yet", 32'(wd_fire_o), 32'd0);
      step(1'b0, 2'd0, 32'd0);
      check("R8 fired", 32'(wd_fire_o), 32'd1);

      // R9: soft reset
      cur_tag = "R9";
      step(1'b1, 2'd1, 32'd7);
      step(1'b1, 2'd2, 32'd0);
      check("R9 bit clear ignored", 32'(wd_fire_o), 32'd1);
      peek("R9 preset kept", 2'd1, 32'd7);
      step(1'b1, 2'd2, 32'd1);
      check("R9 fire cleared", 32'(wd_fire_o), 32'd0);
      check("R9 granted low", 32'(granted_o), 32'd0);
      peek("R9 preset zero", 2'd1, 32'd0);
      peek("R9 ctrl zero", 2'd0, 32'd0);

      // R8: rearm with zero preset fires right away
      cur_tag = "R8";
      step(1'b1, 2'd0, 32'h2);
      check("R8 granted", 32'(granted_o), 32'd1);
      step(1'b0, 2'd0, 32'd0);
      check("R8 rearm zero fires", 32'(wd_fire_o), 32'd1);

      // R2/R10: long run of periodic reloads, then expiry
      cur_tag = "R2";
      step(1'b1, 2'd1, 32'd300);
      step(1'b1, 2'd0, 32'h2);
      for (int k = 0; k < 20; k++) begin
         idle(100);
         step(1'b1, 2'd1, 32'd300);
      end
      check("R10 granted through kicks", 32'(granted_o), 32'd1);
      cur_tag = "R4";
      idle(302);
      check("R4 long expiry", 32'(wd_fire_o), 32'd1);

      finish_run();
   end

endmodule